// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block controls a bank of quasi-bidirectional pins. Each pin has one latch bit that the processor writes, and four pad-driver enables: a pull-down, a strong pull-up, a medium pull-up and a very weak keeper. A latch bit at 0 drives the pin low. A latch bit at 1 hands the pin to the pull-ups, so the pin can also serve as an input. When a pin's driven level rises, the strong pull-up fires for a fixed number of clocks to charge the pin quickly. The medium pull-up then holds the pin high for as long as the sensed level stays high. The keeper stays on for as long as the driven level is 1.

The sensed pin levels pass through a synchronizer. From there they feed the read-pin path and the alternate inputs, for example a timer clock or a capture trigger. An alternate input only sees the pin when its latch bit is 1. A per-pin PWM enable lets the PWM output take the place of the latch as the driven level. A registered read port returns either the latch contents or the synchronized pin levels, depending on which strobe is raised.

Top module: `qbd_port`

## Requirements
- R1: Reset (synchronous, active-high) sets every latch bit to 1 and produces the following outputs: all pull-down enables 0, all keeper enables 1, all strong enables 0 and read data 0. Leaving reset starts no strong pulse.
- R2: The pull-down enable of a pin equals the inverse of its driven level. It is updated at the second rising edge after the write strobe that changes the latch.
- R3: When a pin's driven level goes from 0 to 1, its strong pull-up enable is high for exactly PULSE_CYCLES (default 2) cycles, starting at the second edge after the write strobe, and is low afterwards.
- R4: The medium pull-up enable of a pin is 1 only when its driven level is 1 and its synchronized pin level is high. It turns off when the sensed level is low.
- R5: The keeper enable of a pin equals its driven level, whatever the sensed pin level is.
- R6: In any cycle, a pin never has its pull-down enable together with any of its pull-up enables.
- R7: A write that keeps a bit at 1, or that changes a bit from 1 to 0, raises no strong pulse on that bit.
- R8: Alternate input bit i equals the synchronized level of pin i ANDed with latch bit i. It is 0 whenever the latch bit is 0.
- R9: When pwm_en[i] is 1, the driven level of pin i is pwm_out[i] and the latch bit has no effect on the pad enables.
- R10: A read-latch strobe loads rd_data with the latch contents as they stood before a write in the same cycle. When the read-latch and read-pin strobes are both raised, the read-latch strobe wins.
- R11: A read-pin strobe loads rd_data with the synchronized pin levels. A change on pin_in can first be seen by a strobe at the (SYNC_STAGES+1)-th edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Latch write data |
| rd_latch | input | 1 | Read-latch strobe |
| rd_pin | input | 1 | Read-pin strobe |
| rd_data | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Sensed pin levels from the pads |
| pwm_en | input | WIDTH | Per-pin PWM override enable |
| pwm_out | input | WIDTH | Per-pin PWM level |
| pd_en | output | WIDTH | Pull-down enables |
| pu_strong_en | output | WIDTH | Strong pull-up enables |
| pu_med_en | output | WIDTH | Medium pull-up enables |
| pu_weak_en | output | WIDTH | Keeper enables |
| alt_in | output | WIDTH | Gated pin levels for alternate input functions |

## Verification
A latch write and a read-latch strobe can land in the same cycle, and the read must then return the value the latch held before the write. The bench raises both strobes together with new data that differs from the current latch. It then checks that rd_data holds the old value and that a following read returns the new one. The read-latch and read-pin strobes are also raised together, with the latch and pin patterns chosen to differ, so that a wrong priority shows up in rd_data.

// File: rtl/qbd_port_pkg.sv
package qbd_port_pkg;
  typedef struct packed {
    logic pull_dn;
    logic pu_strong;
    logic pu_med;
    logic pu_weak;
  } pad_drv_t;
endpackage

// File: rtl/qbd_sync.sv
module qbd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qbd_pin_drv.sv
module qbd_pin_drv
  import qbd_port_pkg::*;
#(
  parameter int PULSE_CYCLES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     level,
  input  logic     pin_s,
  output pad_drv_t drv
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic          lvl_q;
  logic [CW-1:0] cnt;
  logic          med_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b1;
      cnt   <= '0;
      med_q <= 1'b0;
    end else begin
      lvl_q <= level;
      med_q <= level & pin_s;
      if (!level)
        cnt <= '0;
      else if (!lvl_q)
        cnt <= CW'(PULSE_CYCLES);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign drv.pull_dn   = ~lvl_q;
  assign drv.pu_strong = (cnt != '0);
  assign drv.pu_med    = med_q;
  assign drv.pu_weak   = lvl_q;
endmodule

// File: rtl/qbd_readback.sv
module qbd_readback #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_latch,
  input  logic             rd_pin,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] pin_s,
  output logic [WIDTH-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (rd_latch) rd_data <= latch_q;
    else if (rd_pin)   rd_data <= pin_s;
  end
endmodule

// File: rtl/qbd_port.sv
module qbd_port
  import qbd_port_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_latch,
  input  logic             rd_pin,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] pwm_en,
  input  logic [WIDTH-1:0] pwm_out,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] pu_strong_en,
  output logic [WIDTH-1:0] pu_med_en,
  output logic [WIDTH-1:0] pu_weak_en,
  output logic [WIDTH-1:0] alt_in
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] level;
  logic [WIDTH-1:0] alt_q;

  always_ff @(posedge clk) begin
    if (rst)        latch_q <= '1;
    else if (wr_en) latch_q <= wr_data;
  end

  qbd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  assign level = (pwm_en & pwm_out) | (~pwm_en & latch_q);

  always_ff @(posedge clk) begin
    if (rst) alt_q <= '0;
    else     alt_q <= pin_s & latch_q;
  end
  assign alt_in = alt_q;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      pad_drv_t drv;
      qbd_pin_drv #(.PULSE_CYCLES(PULSE_CYCLES)) u_drv (
        .clk(clk), .rst(rst), .level(level[i]), .pin_s(pin_s[i]), .drv(drv)
      );
      assign pd_en[i]        = drv.pull_dn;
      assign pu_strong_en[i] = drv.pu_strong;
      assign pu_med_en[i]    = drv.pu_med;
      assign pu_weak_en[i]   = drv.pu_weak;
    end
  endgenerate

  qbd_readback #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst(rst), .rd_latch(rd_latch), .rd_pin(rd_pin),
    .latch_q(latch_q), .pin_s(pin_s), .rd_data(rd_data)
  );
endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] pd_en,
  input logic [WIDTH-1:0] pu_strong_en,
  input logic [WIDTH-1:0] pu_med_en,
  input logic [WIDTH-1:0] pu_weak_en
);
  logic [WIDTH-1:0] strong_d, strong_dd;

  always_ff @(posedge clk) begin
    if (rst) begin
      strong_d  <= '0;
      strong_dd <= '0;
    end else begin
      strong_d  <= pu_strong_en;
      strong_dd <= strong_d;
    end
  end

  // R6
  pd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_en & (pu_strong_en | pu_med_en | pu_weak_en)) == '0);

  // R3
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strong_d & ~strong_dd & pu_weak_en & ~pu_strong_en) == '0);

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (pu_strong_en & strong_d & strong_dd) == '0);

  // R4
  med_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pu_med_en & ~pu_weak_en) == '0);

  // R5
  strong_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pu_strong_en & ~pu_weak_en) == '0);
endmodule

bind qbd_port qbd_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .pd_en(pd_en), .pu_strong_en(pu_strong_en),
  .pu_med_en(pu_med_en), .pu_weak_en(pu_weak_en)
);

// File: tb/qbd_port_test.sv
module qbd_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_latch = 1'b0, rd_pin = 1'b0;
  logic [W-1:0] wr_data = '0, pin_in = '1, pwm_en = '0, pwm_out = '0;
  logic [W-1:0] rd_data, pd_en, pu_strong_en, pu_med_en, pu_weak_en, alt_in;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] latch_m = '1;

  always #2.5 clk = ~clk;

  qbd_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_latch(rd_latch), .rd_pin(rd_pin), .rd_data(rd_data),
    .pin_in(pin_in), .pwm_en(pwm_en), .pwm_out(pwm_out),
    .pd_en(pd_en), .pu_strong_en(pu_strong_en), .pu_med_en(pu_med_en),
    .pu_weak_en(pu_weak_en), .alt_in(alt_in)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] drv_level(input logic [W-1:0] l, input logic [W-1:0] pe,
                                             input logic [W-1:0] po);
    return (pe & po) | (~pe & l);
  endfunction

  // write with pwm off; checks the strong pulse window cycle by cycle
  task automatic do_write(input logic [W-1:0] d);
    logic [W-1:0] rise;
    rise = d & ~latch_m;
    wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    chk("R3 before pulse", pu_strong_en, '0);
    step();
    chk("R3/R7 pulse cycle 1", pu_strong_en, rise);
    chk("R2 pull-down", pd_en, ~d);
    step();
    chk("R3/R7 pulse cycle 2", pu_strong_en, rise);
    step();
    chk("R3 pulse end", pu_strong_en, '0);
    latch_m = d;
  endtask

  task automatic check_steady();
    logic [W-1:0] lv;
    repeat (5) step();
    lv = drv_level(latch_m, pwm_en, pwm_out);
    chk(pwm_en != '0 ? "R9 pull-down" : "R2 pull-down", pd_en, ~lv);
    chk("R5 keeper", pu_weak_en, lv);
    chk("R7 no stray pulse", pu_strong_en, '0);
    chk("R4 medium", pu_med_en, lv & pin_in);
    chk("R8 alt input", alt_in, pin_in & latch_m);
    rd_latch = 1'b1; step(); rd_latch = 1'b0;
    chk("R10 read latch", rd_data, latch_m);
    rd_pin = 1'b1; step(); rd_pin = 1'b0;
    chk("R11 read pin", rd_data, pin_in);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1
    chk("R1 pull-down", pd_en, '0);
    chk("R1 keeper", pu_weak_en, '1);
    chk("R1 strong", pu_strong_en, '0);
    chk("R1 rd_data", rd_data, '0);
    step();
    chk("R1 no pulse after reset", pu_strong_en, '0);
    rd_latch = 1'b1; step(); rd_latch = 1'b0;
    chk("R1 latch reset", rd_data, '1);

    // directed corners
    do_write(8'h00);             // R2 all low
    check_steady();
    do_write(8'hFF);             // R3 all rise
    do_write(8'hFF);             // R7 stays high
    do_write(8'h5A);             // R7 falling bits
    do_write(8'h5F);             // R3 partial rise
    pin_in = 8'h0F;              // R4/R5 pin pulled low externally
    check_steady();

    // random phase, pwm off
    for (int k = 0; k < 30; k++) begin
      pin_in = W'($urandom);
      do_write(W'($urandom));
      check_steady();
    end

    // random phase, pwm override
    for (int k = 0; k < 15; k++) begin
      pwm_en  = W'($urandom);
      pwm_out = W'($urandom);
      pin_in  = W'($urandom);
      check_steady();
    end
    pwm_en = '0; pwm_out = '0;
    repeat (4) step();

    // R11 synchronizer latency
    pin_in = 8'h3C; repeat (4) step();
    pin_in = 8'hC3; rd_pin = 1'b1;
    step(); chk("R11 latency edge1", rd_data, 8'h3C);
    step(); chk("R11 latency edge2", rd_data, 8'h3C);
    step(); chk("R11 latency edge3", rd_data, 8'hC3);
    rd_pin = 1'b0;

    // R10 write and read-latch in the same cycle
    wr_data = 8'h96; wr_en = 1'b1; rd_latch = 1'b1;
    step();
    wr_en = 1'b0;
    chk("R10 collision old value", rd_data, latch_m);
    latch_m = 8'h96;
    step();
    chk("R10 after collision", rd_data, 8'h96);
    rd_pin = 1'b1;
    step();
    chk("R10 latch priority", rd_data, 8'h96);
    rd_latch = 1'b0; rd_pin = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule